// File: doc/BRIEF.md
# Multiplexed 8-bit Bus Bridge

This block turns single-cycle register requests from internal logic into complete transfers on an external 8-bit bus where the address and the data share the same bidirectional lines. A requester pulses `go_i` with a direction flag, an address and write data. The bridge then runs one bus frame. The frame opens with an address-latch pulse, continues with a read or write strobe, and closes with a one-cycle completion pulse. That pulse carries the direction, the address and, for reads, the byte sampled from the bus.

The bridge runs on the master clock. It also divides that clock by a parameter (four by default) to make the slower clock used by the rest of the logic. Two static pins tell the attached device that the bus is multiplexed and uses the strobe format with separate read and write enables, where the select pin is held low.

The default frame lasts five master cycles: one cycle of address latch, one cycle of address hold, `STROBE_CYC` (2) cycles of strobe, and one cycle of completion. Requests that arrive while a frame is running are dropped.

Top module: `mux_bus_bridge`

## Requirements
- R1: While reset is low and after it is released, `cs_n_o`, `rd_n_o` and `wr_n_o` are high, `ale_o` and `done_o` are low, `slow_clk_o` is low, and `done_rdata_o` is 0.
- R2: A `go_i` sampled while idle makes the next cycle an address-latch cycle. In that cycle `ale_o`=1 for exactly one cycle, `cs_n_o`=0, and AD carries the requested address.
- R3: After the address-latch cycle, AD holds the address for one more cycle with `ale_o`=0 and both strobes high. Then exactly one strobe is low for `STROBE_CYC` cycles: `rd_n_o` when `rw_i`=1 (read), `wr_n_o` when `rw_i`=0 (write). The two strobes are never low together, and a strobe is only low while `cs_n_o`=0.
- R4: On a write, AD carries the write data for the whole strobe and for the cycle after the strobe rises.
- R5: On a read, the bridge releases AD during the strobe. It stores the value on AD at the clock edge that raises `rd_n_o`, and presents that value on `done_rdata_o`.
- R6: In the cycle right after the strobe rises, `done_o`=1 for one cycle, with `cs_n_o` still 0, both strobes high, `done_rw_o` equal to the request's `rw_i`, and `done_addr_o` equal to its address. In the next cycle `cs_n_o`=1.
- R7: A `go_i` that arrives while a frame is in progress has no effect, including in the completion cycle. The bus returns to idle at the normal time and no address-latch cycle follows.
- R8: A write leaves `done_rdata_o` at the value from the most recent read.
- R9: `slow_clk_o` has period `DIV` master cycles and a 50% duty cycle. It first goes high on the (`DIV`/2)-th master clock edge after reset is released.
- R10: `fmt_sel_o` is always 0 (separate read/write strobes) and `muxed_o` is always 1 (shared address/data lines).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | One-cycle request pulse |
| rw_i | input | 1 | Direction: 1 read, 0 write |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data, ignored on reads |
| done_o | output | 1 | One-cycle completion pulse |
| done_rw_o | output | 1 | Direction of the last transfer |
| done_addr_o | output | 8 | Address of the last transfer |
| done_rdata_o | output | 8 | Data of the last read |
| cs_n_o | output | 1 | Chip select, active low |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| fmt_sel_o | output | 1 | Bus format select, tied low |
| muxed_o | output | 1 | Multiplexed-bus flag, tied high |
| slow_clk_o | output | 1 | Divided system clock |
| ad_io | inout | 8 | Shared address/data bus |

## Verification
Two events can fall in the same cycle: the completion pulse that ends a frame, and a fresh request from the requester. The bench raises `go_i` in the completion cycle, and also during the address-hold cycle. One cycle later it checks that chip select is high and that no address-latch pulse has appeared. A later transfer with new values then confirms that the latched request was not overwritten.

// File: rtl/mbb_pkg.sv
package mbb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ALE   = 3'd1,
    PH_AHOLD = 3'd2,
    PH_STRB  = 3'd3,
    PH_END   = 3'd4
  } phase_t;

  // width of a counter that must hold values 0..n-1
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // divided clock level for a given divider count value
  function automatic logic slow_level(input int unsigned cnt, input int unsigned div);
    return (cnt >= div / 2);
  endfunction

  // AD is owned by the bridge in address phases and, for writes, in data phases
  function automatic logic ad_owned(input phase_t ph, input logic rd);
    return (ph == PH_ALE) || (ph == PH_AHOLD) ||
           (!rd && ((ph == PH_STRB) || (ph == PH_END)));
  endfunction

endpackage

// File: rtl/mbb_clkdiv.sv
module mbb_clkdiv #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic slow_clk_o
);
  localparam int unsigned CW = mbb_pkg::cnt_w(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;
  logic          slow_q;

  assign cnt_nx = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slow_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      slow_q <= mbb_pkg::slow_level(int'(cnt_nx), DIV);
    end
  end

  assign slow_clk_o = slow_q;
endmodule

// File: rtl/mbb_seq.sv
module mbb_seq
  import mbb_pkg::*;
#(
  parameter int unsigned STROBE_CYC = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go_i,
  input  logic   rd_q,
  output phase_t phase_o,
  output logic   accept_o,
  output logic   capture_o,
  output logic   ale_o,
  output logic   cs_n_o,
  output logic   rd_n_o,
  output logic   wr_n_o,
  output logic   done_o
);
  localparam int unsigned SW = cnt_w(STROBE_CYC);
  localparam logic [SW-1:0] SLAST = SW'(STROBE_CYC - 1);

  phase_t        ph_q, ph_nx;
  logic [SW-1:0] scnt_q;
  logic          strb_last;

  assign strb_last = (scnt_q == SLAST);
  assign accept_o  = go_i && (ph_q == PH_IDLE);

  always_comb begin
    ph_nx = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (go_i) ph_nx = PH_ALE;
      PH_ALE:   ph_nx = PH_AHOLD;
      PH_AHOLD: ph_nx = PH_STRB;
      PH_STRB:  if (strb_last) ph_nx = PH_END;
      PH_END:   ph_nx = PH_IDLE;
      default:  ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      scnt_q <= '0;
    end else begin
      ph_q <= ph_nx;
      if (ph_q == PH_STRB && !strb_last) scnt_q <= scnt_q + 1'b1;
      else                               scnt_q <= '0;
    end
  end

  assign phase_o   = ph_q;
  assign capture_o = (ph_q == PH_STRB) && strb_last && rd_q;
  assign ale_o     = (ph_q == PH_ALE);
  assign cs_n_o    = (ph_q == PH_IDLE);
  assign rd_n_o    = !((ph_q == PH_STRB) && rd_q);
  assign wr_n_o    = !((ph_q == PH_STRB) && !rd_q);
  assign done_o    = (ph_q == PH_END);
endmodule

// File: rtl/mbb_addata.sv
module mbb_addata
  import mbb_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic          capture_i,
  input  phase_t        phase_i,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] ad_in,
  output logic          rd_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] rdata_q,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe
);
  localparam int unsigned BW = (AW > DW) ? AW : DW;

  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept_i) begin
        rd_q    <= rw_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (capture_i) rdata_q <= ad_in;
    end
  end

  logic addr_phase;
  assign addr_phase = (phase_i == PH_ALE) || (phase_i == PH_AHOLD);
  assign ad_oe      = ad_owned(phase_i, rd_q);
  assign ad_out     = addr_phase ? DW'(BW'(addr_q)) : wdata_q;
endmodule

// File: rtl/mux_bus_bridge.sv
module mux_bus_bridge #(
  parameter int unsigned DIV        = 4,
  parameter int unsigned STROBE_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic       rw_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic       done_o,
  output logic       done_rw_o,
  output logic [7:0] done_addr_o,
  output logic [7:0] done_rdata_o,
  output logic       cs_n_o,
  output logic       ale_o,
  output logic       rd_n_o,
  output logic       wr_n_o,
  output logic       fmt_sel_o,
  output logic       muxed_o,
  output logic       slow_clk_o,
  inout  wire  [7:0] ad_io
);
  import mbb_pkg::*;

  phase_t     phase;
  logic       accept, capture, rd_q, ad_oe, idle;
  logic [7:0] ad_out, ad_in;

  assign ad_io = ad_oe ? ad_out : 8'hzz;
  assign ad_in = ad_io;
  assign idle  = (phase == PH_IDLE);

  mbb_clkdiv #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .slow_clk_o(slow_clk_o)
  );

  mbb_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .rd_q(rd_q),
    .phase_o(phase), .accept_o(accept), .capture_o(capture),
    .ale_o(ale_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .done_o(done_o)
  );

  mbb_addata #(.AW(8), .DW(8)) u_ad (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .capture_i(capture),
    .phase_i(phase), .rw_i(rw_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .ad_in(ad_in), .rd_q(rd_q), .addr_q(done_addr_o), .rdata_q(done_rdata_o),
    .ad_out(ad_out), .ad_oe(ad_oe)
  );

  assign done_rw_o = rd_q;
  assign fmt_sel_o = 1'b0;
  assign muxed_o   = 1'b1;
endmodule

// File: rtl/mbb_checker.sv
module mbb_checker (
  input logic clk,
  input logic rst_n,
  input logic go_i,
  input logic idle,
  input logic ad_oe,
  input logic ale_o,
  input logic cs_n_o,
  input logic rd_n_o,
  input logic wr_n_o,
  input logic done_o,
  input logic fmt_sel_o,
  input logic muxed_o
);
  // R2: accepted request opens an address-latch cycle
  p_accept_ale_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && idle) |=> (ale_o && !cs_n_o && ad_oe));
  // R2: latch pulse lasts one cycle
  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ale_o);
  // R3: address still driven after latch falls, strobes high
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> (ad_oe && rd_n_o && wr_n_o && !cs_n_o));
  // R3: strobes exclusive
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n_o || wr_n_o));
  // R3: strobe only under chip select
  p_strobe_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_o || !wr_n_o) |-> !cs_n_o);
  // R5: bus released while read strobe low
  p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !ad_oe);
  // R6: completion framing
  p_done_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!cs_n_o && rd_n_o && wr_n_o));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && cs_n_o));
  // R7: request during a frame does not start a latch cycle
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && !idle) |=> !ale_o);
  // R10: static pins
  always @(posedge clk) begin
    if (rst_n) begin
      p_static_r10: assert (!fmt_sel_o && muxed_o);
    end
  end
endmodule

bind mux_bus_bridge mbb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .go_i(go_i), .idle(idle), .ad_oe(ad_oe),
  .ale_o(ale_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
  .done_o(done_o), .fmt_sel_o(fmt_sel_o), .muxed_o(muxed_o)
);

// File: tb/mux_bus_bridge_test.sv
`timescale 1ns/1ps
module mux_bus_bridge_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, rw = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic done, done_rw, cs_n, ale, rd_n, wr_n, fmt, mux, slow;
  logic [7:0] done_addr, done_rdata;
  logic tb_drv = 1'b0;
  logic [7:0] tb_val = '0;
  wire  [7:0] ad;
  int checks = 0, errors = 0;
  logic [7:0] last_rd = 8'h00;

  always #2.5 clk = ~clk;
  assign ad = tb_drv ? tb_val : 8'hzz;

  mux_bus_bridge uut (
    .clk(clk), .rst_n(rst_n), .go_i(go), .rw_i(rw), .addr_i(addr),
    .wdata_i(wdata), .done_o(done), .done_rw_o(done_rw),
    .done_addr_o(done_addr), .done_rdata_o(done_rdata), .cs_n_o(cs_n),
    .ale_o(ale), .rd_n_o(rd_n), .wr_n_o(wr_n), .fmt_sel_o(fmt),
    .muxed_o(mux), .slow_clk_o(slow), .ad_io(ad)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {rw(1=read), addr, wdata, value the device returns on reads}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 8'h76, 8'hA5, 8'h00},
    {1'b1, 8'h10, 8'h00, 8'h3C},
    {1'b0, 8'hFF, 8'h00, 8'h00},
    {1'b1, 8'h00, 8'hEE, 8'hC3},
    {1'b0, 8'h5A, 8'hFF, 8'h11},
    {1'b1, 8'hA1, 8'h00, 8'h00}
  };

  task automatic xfer(input logic r, input logic [7:0] a, input logic [7:0] w,
                      input logic [7:0] dev, input logic poke);
    go = 1'b1; rw = r; addr = a; wdata = w;
    @(negedge clk);                   // address-latch cycle
    go = 1'b0;
    chk(ale === 1'b1 && cs_n === 1'b0, "R2 ale/cs", {ale, cs_n}, 2'b10);
    chk(ad === a, "R2 address on AD", ad, a);
    @(negedge clk);                   // address hold
    if (poke) begin go = 1'b1; rw = ~r; addr = ~a; wdata = ~w; end
    chk(ale === 1'b0 && rd_n === 1'b1 && wr_n === 1'b1, "R3 hold strobes", {ale, rd_n, wr_n}, 3'b011);
    chk(ad === a, "R3 address held", ad, a);
    if (r) begin tb_drv = 1'b1; tb_val = dev; end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);                 // strobe cycles
      go = 1'b0;
      chk(rd_n === !r && wr_n === r, "R3 strobe select", {rd_n, wr_n}, {!r, r});
      if (!r) chk(ad === w, "R4 write data on AD", ad, w);
    end
    @(negedge clk);                   // completion cycle
    tb_drv = 1'b0;
    chk(done === 1'b1 && cs_n === 1'b0 && rd_n && wr_n, "R6 done frame", {done, cs_n, rd_n, wr_n}, 4'b1011);
    chk(done_rw === r, "R6 rw echo", done_rw, r);
    chk(done_addr === a, "R6 addr echo", done_addr, a);
    if (!r) chk(ad === w, "R4 write data after strobe", ad, w);
    if (r) begin
      last_rd = dev;
      chk(done_rdata === dev, "R5 read capture", done_rdata, dev);
    end else
      chk(done_rdata === last_rd, "R8 write keeps read data", done_rdata, last_rd);
    if (poke) go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk(done === 1'b0 && cs_n === 1'b1, "R6 frame closes", {done, cs_n}, 2'b01);
    chk(ale === 1'b0, "R7 no restart while busy", ale, 0);
  endtask

  initial begin
    #20000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && ale === 1'b0 && rd_n && wr_n, "R1 bus idle in reset", {cs_n, ale, rd_n, wr_n}, 4'b1011);
    chk(done === 1'b0 && slow === 1'b0 && done_rdata === 8'h00, "R1 outputs in reset", {done, slow, done_rdata}, 0);
    chk(fmt === 1'b0 && mux === 1'b1, "R10 static pins", {fmt, mux}, 2'b01);
    rst_n = 1'b1;
    // R9: after release expect 0,1,1,0 repeating across master edges
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(slow === (((i + 1) % 4) >= 2), "R9 slow clock", slow, ((i + 1) % 4) >= 2);
    end
    chk(cs_n === 1'b1 && done === 1'b0, "R1 idle after release", {cs_n, done}, 2'b10);
    for (int v = 0; v < 6; v++) begin
      xfer(VEC[v][24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 1'b0);
      @(negedge clk);
    end
    // R7: requests in hold and in completion cycle are dropped
    xfer(1'b1, 8'h42, 8'h00, 8'h99, 1'b1);
    @(negedge clk);
    chk(cs_n === 1'b1 && ale === 1'b0, "R7 stays idle", {cs_n, ale}, 2'b10);
    // back-to-back accepted after idle, write right after dropped requests
    xfer(1'b0, 8'h24, 8'h81, 8'h00, 1'b0);
    chk(fmt === 1'b0 && mux === 1'b1, "R10 static pins late", {fmt, mux}, 2'b01);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule